// File: doc/BRIEF.md
# Sigma-delta bitstream sampler

This block sits between a one-bit modulator and the decimation filter. It takes an external modulator clock and a data line, brings both into the system clock domain, and emits one data bit with a one-cycle strobe each time the selected mode calls for a sample. A 3-bit mode input selects the capture rule. The modulator clock can be sampled on its rising edges, its falling edges, both edges, or every second edge of one polarity. In the Manchester mode the bit timing is recovered from the data line alone.

Each line has its own synchroniser bypass, so a modulator that already runs in step with the system clock can skip the two-stage delay. A watchdog on the modulator clock raises a sticky error flag when the clock stops in any clock-driven mode. The flag stays set until a clear pulse arrives.

Top module: `sd_bitstream_sampler`

## Requirements
- R1: With `mode_i` = 0, one sample is emitted per rising edge of the modulator clock, carrying the data level present at that edge.
- R2: With `mode_i` = 1, a sample is emitted on every rising and every falling edge, in edge order, giving two bits per modulator clock period.
- R3: With `mode_i` = 3, one sample is emitted per falling edge of the modulator clock.
- R4: With `mode_i` = 4 (rising) or 5 (falling), only every second qualifying edge produces a sample. The count restarts on any change of `mode_i`, so the first qualifying edge after a change is skipped and the second one is sampled.
- R5: With `mode_i` = 2, bits are decoded from a Manchester-coded data line, and the modulator clock is ignored. A low-to-high transition in mid-bit is a 1 and a high-to-low transition is a 0. After idle, the first data transition is taken as the mid-bit of the first bit and is emitted with the level it goes to. The first two bits must be equal, so the spacing of the first two transitions gives the half-bit period. Afterwards, a transition is accepted as the next mid-bit only once 1.5 half-bit periods have passed since the last one.
- R6: In `mode_i` = 2, when no mid-bit transition arrives within 3 half-bit periods, the decoder returns to idle. The next stream is then measured afresh and may use a different bit rate.
- R7: With `clk_sync_en_i` = 1, a sample strobe appears 3 system clocks after the modulator clock input changes. With it at 0, the strobe appears after 1 system clock. With `dat_sync_en_i` = 1, the sampled data is delayed by the same two stages as the clock. With it at 0, the raw data line is sampled.
- R8: Mode values 6 and 7 produce no samples, whatever the input lines do.
- R9: In modes 0, 1, 3, 4 and 5, `clk_err_o` goes high once 255 consecutive system clocks pass with no modulator clock edge, and it then stays high. In mode 2 and in the reserved modes the watchdog is idle and the flag does not change.
- R10: A cycle with `err_clr_i` high clears `clk_err_o` on the next clock and restarts the 255-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clk_i | input | 1 | Modulator clock, asynchronous |
| mod_dat_i | input | 1 | Modulator data line, asynchronous |
| mode_i | input | 3 | Capture mode: 0 rise, 1 both, 2 Manchester, 3 fall, 4 every 2nd rise, 5 every 2nd fall, 6-7 reserved |
| clk_sync_en_i | input | 1 | Two-stage synchroniser on the clock line when 1 |
| dat_sync_en_i | input | 1 | Two-stage synchroniser on the data line when 1 |
| err_clr_i | input | 1 | Clears the clock-loss flag |
| bit_o | output | 1 | Captured data bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a new `bit_o` |
| clk_err_o | output | 1 | Sticky modulator clock-loss flag |

## Verification
The bench drives data that changes between edges, so a design that samples on the wrong polarity or double-counts edges delivers a bit sequence that differs from the expected queue. Modes 4 and 5 are checked across a mode change in mid-phase: a design that keeps its phase count across the change samples the first falling edge instead of skipping it. Two Manchester streams are sent with different half-bit periods and a silent gap between them, and the clock line toggles throughout. A decoder that accepts boundary transitions, never resynchronises or listens to the clock produces extra or wrong bits. The bench also measures the strobe latency with each synchroniser on and off, and moves the data line one cycle after the clock edge so that a swapped data bypass captures the wrong level. It runs the watchdog to just under and just over its limit, and then checks that the flag stays set, clears and re-arms.

// File: rtl/sd_bitstream_sampler.sv
module sd_bitstream_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 255,
  parameter int HALF_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_clk_i,
  input  logic       mod_dat_i,
  input  logic [2:0] mode_i,
  input  logic       clk_sync_en_i,
  input  logic       dat_sync_en_i,
  input  logic       err_clr_i,
  output logic       bit_o,
  output logic       bit_vld_o,
  output logic       clk_err_o
);

  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam int CNT_W  = HALF_W + 2;
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);
  localparam logic [CNT_W-1:0]  HALF_MAX  = CNT_W'((1 << HALF_W) - 1);

  typedef enum logic [1:0] {M_IDLE, M_MEAS, M_RUN} man_st_t;

  logic [SYNC_STAGES-1:0] ck_pipe, dt_pipe;
  logic ck_s, dt_s, ck_q, dt_q;
  logic rise, fall, dt_edge;
  logic [2:0] mode_q;
  logic phase, clk_cap, clocked;
  man_st_t man_st;
  logic man_on, man_emit;
  logic [CNT_W-1:0] man_cnt;
  logic [HALF_W-1:0] half;
  logic [CNT_W:0] cnt_x2, quiet_at;
  logic [LOSS_W-1:0] loss_cnt;

  // input synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_pipe <= '0;
      dt_pipe <= '0;
      ck_q    <= 1'b0;
      dt_q    <= 1'b0;
    end else begin
      ck_pipe <= {ck_pipe[SYNC_STAGES-2:0], mod_clk_i};
      dt_pipe <= {dt_pipe[SYNC_STAGES-2:0], mod_dat_i};
      ck_q    <= ck_s;
      dt_q    <= dt_s;
    end
  end

  assign ck_s    = clk_sync_en_i ? ck_pipe[SYNC_STAGES-1] : mod_clk_i;
  assign dt_s    = dat_sync_en_i ? dt_pipe[SYNC_STAGES-1] : mod_dat_i;
  assign rise    = ck_s & ~ck_q;
  assign fall    = ~ck_s & ck_q;
  assign dt_edge = dt_s ^ dt_q;
  assign clocked = (mode_i != 3'd2) && (mode_i[2:1] != 2'b11);

  // clock-edge capture modes
  always_comb begin
    case (mode_i)
      3'd0:    clk_cap = rise;
      3'd1:    clk_cap = rise | fall;
      3'd3:    clk_cap = fall;
      3'd4:    clk_cap = rise & phase;
      3'd5:    clk_cap = fall & phase;
      default: clk_cap = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      phase  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (mode_i != mode_q)
        phase <= 1'b0;
      else if ((mode_i == 3'd4 && rise) || (mode_i == 3'd5 && fall))
        phase <= ~phase;
    end
  end

  // Manchester recovery
  assign man_on   = (mode_i == 3'd2);
  assign cnt_x2   = {man_cnt, 1'b0};
  assign quiet_at = {2'b00, half, 1'b0} + {3'b000, half};
  assign man_emit = man_on && dt_edge &&
                    (man_st == M_IDLE || (man_st == M_RUN && cnt_x2 >= quiet_at));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_st  <= M_IDLE;
      man_cnt <= '0;
      half    <= '0;
    end else if (!man_on) begin
      man_st  <= M_IDLE;
      man_cnt <= '0;
    end else begin
      case (man_st)
        M_IDLE: if (dt_edge) begin
          man_st  <= M_MEAS;
          man_cnt <= CNT_W'(1);
        end
        M_MEAS: if (dt_edge) begin
          half    <= man_cnt[HALF_W-1:0];
          man_st  <= M_RUN;
          man_cnt <= man_cnt + 1'b1;
        end else if (man_cnt == HALF_MAX) begin
          man_st <= M_IDLE;
        end else begin
          man_cnt <= man_cnt + 1'b1;
        end
        M_RUN: if (man_emit) begin
          man_cnt <= CNT_W'(1);
        end else if ({1'b0, man_cnt} >= quiet_at) begin
          man_st <= M_IDLE;
        end else begin
          man_cnt <= man_cnt + 1'b1;
        end
        default: man_st <= M_IDLE;
      endcase
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= clk_cap | man_emit;
      if (clk_cap | man_emit) bit_o <= dt_s;
    end
  end

  // clock-loss watchdog
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_cnt  <= '0;
      clk_err_o <= 1'b0;
    end else if (err_clr_i) begin
      loss_cnt  <= '0;
      clk_err_o <= 1'b0;
    end else if (!clocked || rise || fall) begin
      loss_cnt <= '0;
    end else begin
      if (loss_cnt == LOSS_LAST) clk_err_o <= 1'b1;
      else loss_cnt <= loss_cnt + 1'b1;
    end
  end

  assert_rise_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_o && $past(mode_i) == 3'd0) |-> ck_q);

  assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_o && $past(mode_i) == 3'd3) |-> !ck_q);

  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b11) |=> !bit_vld_o);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err_o && !err_clr_i) |=> clk_err_o);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> !clk_err_o);

endmodule

// File: tb/sd_bitstream_sampler_tb.sv
module sd_bitstream_sampler_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_clk = 1'b0, mod_dat = 1'b0;
  logic [2:0] mode = 3'd0;
  logic ck_sync = 1'b1, dt_sync = 1'b1, err_clr = 1'b0;
  logic bit_o, bit_vld, clk_err;

  int checks = 0;
  int fails = 0;
  bit exp_bits[$];
  string exp_req[$];

  always #10 clk = ~clk;

  sd_bitstream_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .mod_clk_i(mod_clk), .mod_dat_i(mod_dat),
    .mode_i(mode), .clk_sync_en_i(ck_sync), .dat_sync_en_i(dt_sync),
    .err_clr_i(err_clr), .bit_o(bit_o), .bit_vld_o(bit_vld), .clk_err_o(clk_err)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(bit b, string req);
    exp_bits.push_back(b);
    exp_req.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bit_vld) begin
      if (exp_bits.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R8 unexpected sample actual=%0d expected=none", bit_o);
      end else begin
        bit e;
        string r;
        e = exp_bits.pop_front();
        r = exp_req.pop_front();
        check(bit_o == e, r, bit_o, e);
      end
    end
  end

  task automatic period(bit dr, bit df, bit pr, bit pf, string req);
    mod_dat = dr;
    tick(4);
    if (pr) expect_bit(dr, req);
    mod_clk = 1'b1;
    tick(4);
    mod_dat = df;
    tick(4);
    if (pf) expect_bit(df, req);
    mod_clk = 1'b0;
    tick(4);
  endtask

  task automatic set_mode(logic [2:0] m);
    tick(1);
    mode = m;
    tick(4);
  endtask

  task automatic pulse_clear();
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
  endtask

  task automatic latency(bit sync_ck, int exp, string req);
    int n;
    ck_sync = sync_ck;
    mod_clk = 1'b0;
    tick(8);
    mod_dat = 1'b1;
    tick(4);
    expect_bit(1'b1, req);
    mod_clk = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (bit_vld) break;
    end
    check(n == exp, req, n, exp);
    tick(4);
    mod_clk = 1'b0;
    tick(8);
  endtask

  task automatic data_skew(bit sync_dt, bit exp, string req);
    dt_sync = sync_dt;
    mod_clk = 1'b0;
    mod_dat = 1'b0;
    tick(8);
    expect_bit(exp, req);
    mod_clk = 1'b1;
    tick(1);
    mod_dat = 1'b1;
    tick(8);
    mod_clk = 1'b0;
    tick(8);
  endtask

  task automatic man_stream(int hb, logic [15:0] bits, int n, string req);
    for (int i = 0; i < n; i++) begin
      mod_dat = ~bits[i];
      for (int k = 0; k < hb; k++) begin
        if (k % 3 == 0) mod_clk = ~mod_clk;
        tick(1);
      end
      expect_bit(bits[i], req);
      mod_dat = bits[i];
      for (int k = 0; k < hb; k++) begin
        if (k % 3 == 0) mod_clk = ~mod_clk;
        tick(1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    check(bit_vld == 1'b0, "R1", bit_vld, 0);
    check(bit_o == 1'b0, "R1", bit_o, 0);
    check(clk_err == 1'b0, "R9", clk_err, 0);
    rst_n = 1'b1;
    tick(4);

    // R1 rising only
    period(1, 0, 1, 0, "R1");
    period(0, 1, 1, 0, "R1");
    period(1, 1, 1, 0, "R1");
    period(0, 0, 1, 0, "R1");
    // R2 both edges
    set_mode(3'd1);
    period(1, 0, 1, 1, "R2");
    period(0, 1, 1, 1, "R2");
    period(1, 1, 1, 1, "R2");
    period(0, 0, 1, 1, "R2");
    // R3 falling only
    set_mode(3'd3);
    period(1, 0, 0, 1, "R3");
    period(0, 1, 0, 1, "R3");
    period(1, 1, 0, 1, "R3");
    period(0, 0, 0, 1, "R3");
    // R4 every second edge, phase restarted by mode change
    set_mode(3'd4);
    period(1, 0, 0, 0, "R4");
    period(0, 1, 1, 0, "R4");
    period(1, 0, 0, 0, "R4");
    set_mode(3'd5);
    period(0, 1, 0, 0, "R4");
    period(1, 0, 0, 1, "R4");
    period(1, 1, 0, 0, "R4");
    period(0, 1, 0, 1, "R4");
    // R8 reserved modes
    set_mode(3'd6);
    period(1, 0, 0, 0, "R8");
    period(0, 1, 0, 0, "R8");
    set_mode(3'd7);
    period(1, 0, 0, 0, "R8");
    period(0, 1, 0, 0, "R8");
    tick(10);
    check(exp_bits.size() == 0, "R8", exp_bits.size(), 0);

    // R9 and R10 watchdog
    set_mode(3'd0);
    pulse_clear();
    period(1, 0, 1, 0, "R9");
    tick(200);
    check(clk_err == 1'b0, "R9", clk_err, 0);
    tick(100);
    check(clk_err == 1'b1, "R9", clk_err, 1);
    tick(50);
    check(clk_err == 1'b1, "R9", clk_err, 1);
    pulse_clear();
    check(clk_err == 1'b0, "R10", clk_err, 0);
    tick(200);
    check(clk_err == 1'b0, "R10", clk_err, 0);
    tick(100);
    check(clk_err == 1'b1, "R10", clk_err, 1);
    pulse_clear();

    // R7 synchroniser enables
    latency(1'b1, 3, "R7");
    latency(1'b0, 1, "R7");
    ck_sync = 1'b1;
    tick(4);
    data_skew(1'b1, 1'b0, "R7");
    data_skew(1'b0, 1'b1, "R7");
    dt_sync = 1'b1;
    tick(4);

    // R5 and R6 Manchester
    mod_dat = 1'b0;
    mod_clk = 1'b0;
    tick(4);
    pulse_clear();
    set_mode(3'd2);
    tick(20);
    man_stream(8, 16'h004B, 7, "R5");
    tick(60);
    man_stream(6, 16'h002C, 6, "R6");
    tick(300);
    check(clk_err == 1'b0, "R9", clk_err, 0);
    check(exp_bits.size() == 0, "R5", exp_bits.size(), 0);

    summary();
    $finish;
  end
endmodule